// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches a serial infrared receive line and measures how long each mark (line high) and each space (line low) lasts. Whenever the line level changes, it writes one entry to a receive FIFO. The entry holds the level of the pulse that has just ended and its duration in ticks of a programmable timing enable. Software reads the entries and decodes whatever remote-control protocol is in use. The block only measures pulse widths and never recovers data bits.

The raw input first passes through a synchroniser. When demodulation is enabled, a carrier burst is turned into a single mark. The mark starts when carrier edges arrive close together and ends after a quiet period with no edges. When demodulation is off, the synchronised line level is measured directly.

The FIFO read port is show-ahead. If the FIFO is full, a new measurement is dropped and a sticky overrun flag is set. Two interrupt outputs are provided, each with its own enable:

- a receive-service request, raised while data is waiting;
- an overrun indication, raised while the overrun flag is set.

Top module: `irpw_capture`

## Requirements
- R1: The input pin passes through a two-flop synchroniser. With demodulation off and a divider value of 0, a level held on the pin for H clock cycles is recorded with a count of exactly H.
- R2: Each change of the measured level pushes one entry. Bit 16 holds the level of the pulse that ended (1 = mark, pin high; 0 = space). Bits 15:0 hold its tick count. The counter then restarts.
- R3: The timing enable fires once every `div_val`+1 clock cycles. Only cycles carrying the enable are counted, so with `div_val`=3 a 20-cycle mark is recorded as 5.
- R4: The tick counter stops at 0xFFFF instead of wrapping. A longer pulse is recorded as 0xFFFF.
- R5: With demodulation on, a mark begins only on a line edge that arrives within 16 clock cycles of the previous edge. A lone edge, or a steady level, starts no mark and pushes nothing.
- R6: With demodulation on, a mark ends 32 clock cycles after the last edge. A burst of 6 carrier periods of 8 cycles is therefore recorded as a mark of about 72 cycles.
- R7: The FIFO holds 16 entries in order of arrival. `rd_data` shows the oldest entry while `rd_valid` is 1, and a cycle with `rd_en` high removes it.
- R8: A push while the FIFO holds 16 entries is discarded and sets a sticky overrun flag. Only a cycle with `ovr_clr` high clears the flag.
- R9: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and the FIFO is not empty.
- R10: `ovr_irq` is 1 exactly when `ovr_irq_en` is 1 and the overrun flag is set.
- R11: After reset the FIFO is empty, the overrun flag is clear and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw infrared receive line, asynchronous |
| demod_en | input | 1 | 1 selects carrier demodulation, 0 selects direct pulse measurement |
| div_val | input | 16 | Timing-enable divider; a tick occurs every div_val+1 cycles |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | 17 | Oldest entry: bit 16 level, bits 15:0 tick count |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rx_irq_en | input | 1 | Enable for the receive-service interrupt |
| ovr_irq_en | input | 1 | Enable for the overrun interrupt |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_irq | output | 1 | Receive-service interrupt |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The assertions assume the following about the inputs:

- `rd_en` is raised only for single cycles while `rd_valid` is high.
- `demod_en` and `div_val` are changed only while reset is held.
- `ovr_clr` is never pulsed in the same cycle as an overflowing push.

The bench keeps to these rules: it fixes the mode and divider inside its reset task, pops through a task that first checks `rd_valid`, and issues its clear only after the line has been idle long enough that no push can be pending.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned ENTRY_W = CNT_W + 1;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [ENTRY_W-1:0] entry_t;

  localparam cnt_t CNT_MAX = '1;

  // saturating increment of the pulse-width counter
  function automatic cnt_t sat_inc(input cnt_t c);
    return (c == CNT_MAX) ? c : c + cnt_t'(1);
  endfunction

  // level of the finished pulse on top, its width below
  function automatic entry_t pack_entry(input logic lvl, input cnt_t c);
    return {lvl, c};
  endfunction
endpackage

// File: rtl/irpw_sync.sv
module irpw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= din;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/irpw_demod.sv
module irpw_demod #(
  parameter int unsigned CARRIER_WIN = 16,
  parameter int unsigned SPACE_TMO   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic en,
  output logic level,
  output logic edg_o,
  output logic mark_o
);
  localparam int unsigned GAP_W = $clog2(SPACE_TMO + 1);

  logic             din_d;
  logic [GAP_W-1:0] gap;
  logic             mark;
  logic             edg;

  assign edg = din ^ din_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_d <= 1'b0;
      gap   <= GAP_W'(SPACE_TMO);
      mark  <= 1'b0;
    end else begin
      din_d <= din;
      if (edg)
        gap <= '0;
      else if (gap != GAP_W'(SPACE_TMO))
        gap <= gap + GAP_W'(1);
      if (edg && (gap < GAP_W'(CARRIER_WIN)))
        mark <= 1'b1;
      else if (!edg && (gap == GAP_W'(SPACE_TMO - 1)))
        mark <= 1'b0;
    end
  end

  assign level  = en ? mark : din;
  assign edg_o  = edg;
  assign mark_o = mark;
endmodule

// File: rtl/irpw_tick.sv
module irpw_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] dc;

  assign tick = (dc >= div_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dc <= '0;
    else if (tick) dc <= '0;
    else           dc <= dc + DIV_W'(1);
endmodule

// File: rtl/irpw_meter.sv
module irpw_meter
  import irpw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   level,
  input  logic   tick,
  output logic   push,
  output entry_t push_data,
  output cnt_t   cnt_o,
  output logic   trans_o
);
  logic lvl_q;
  cnt_t cnt;
  logic trans;

  assign trans = level ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_q <= level;
      if (trans)
        cnt <= cnt_t'(tick);
      else if (tick)
        cnt <= sat_inc(cnt);
    end
  end

  assign push      = trans;
  assign push_data = pack_entry(lvl_q, cnt);
  assign cnt_o     = cnt;
  assign trans_o   = trans;
endmodule

// File: rtl/irpw_fifo.sv
module irpw_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == FW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= nxt(wp);
      if (do_rd) rp <= nxt(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + FW'(1);
        2'b01:   cnt <= cnt - FW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign fill    = cnt;
endmodule

// File: rtl/irpw_capture.sv
module irpw_capture
  import irpw_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CARRIER_WIN = 16,
  parameter int unsigned SPACE_TMO   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_in,
  input  logic               demod_en,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid,
  input  logic               rx_irq_en,
  input  logic               ovr_irq_en,
  input  logic               ovr_clr,
  output logic               rx_irq,
  output logic               ovr_irq
);
  localparam int unsigned FW = $clog2(FIFO_DEPTH + 1);

  // named internal events, observed by the bound checker
  logic          sync_q;
  logic          level;
  logic          dem_edge;
  logic          dem_mark;
  logic          tick;
  logic          push;
  logic          trans;
  entry_t        push_data;
  cnt_t          width_cnt;
  logic          fifo_empty;
  logic          fifo_full;
  logic [FW-1:0] fifo_fill;
  logic          ovf;
  logic          ovf_event;

  irpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ir_in),
    .dout (sync_q)
  );

  irpw_demod #(.CARRIER_WIN(CARRIER_WIN), .SPACE_TMO(SPACE_TMO)) u_demod (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sync_q),
    .en    (demod_en),
    .level (level),
    .edg_o (dem_edge),
    .mark_o(dem_mark)
  );

  irpw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_val(div_val),
    .tick   (tick)
  );

  irpw_meter u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .tick     (tick),
    .push     (push),
    .push_data(push_data),
    .cnt_o    (width_cnt),
    .trans_o  (trans)
  );

  irpw_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push),
    .wr_data(push_data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .empty  (fifo_empty),
    .full   (fifo_full),
    .fill   (fifo_fill)
  );

  assign ovf_event = push && fifo_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         ovf <= 1'b0;
    else if (ovf_event) ovf <= 1'b1;
    else if (ovr_clr)   ovf <= 1'b0;

  assign rd_valid = !fifo_empty;
  assign rx_irq   = rx_irq_en && !fifo_empty;
  assign ovr_irq  = ovr_irq_en && ovf;
endmodule

// File: rtl/irpw_capture_chk.sv
module irpw_capture_chk
  import irpw_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            push,
  input logic                            fifo_full,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_fill,
  input logic                            ovf,
  input logic                            ovr_clr,
  input logic                            rx_irq,
  input logic                            rd_valid,
  input logic                            ovr_irq,
  input logic                            trans,
  input logic                            tick,
  input cnt_t                            width_cnt,
  input logic                            dem_mark,
  input logic                            dem_edge,
  input logic                            demod_en
);
  // R8: an overflowing push raises the flag
  a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    push && fifo_full |=> ovf);

  // R8: the flag holds until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovr_clr |=> ovf);

  // R8: a clear with no overflow drops the flag
  a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(push && fifo_full) |=> !ovf);

  // R7: the occupancy never exceeds the depth
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  // R9: a receive request needs stored data
  a_r9_rx_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (fifo_fill != '0) && rd_valid);

  // R10: an overrun request needs the flag
  a_r10_ovr_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ovf);

  // R4: a saturated count stays saturated until the next transition
  a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trans && (width_cnt == CNT_MAX) |=> width_cnt == CNT_MAX);

  // R3: the count moves only on timing-enable cycles
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !trans && !tick |=> $stable(width_cnt));

  // R5: a demodulated mark starts only on a line edge
  a_r5_mark_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    demod_en && $rose(dem_mark) |-> $past(dem_edge));
endmodule

bind irpw_capture irpw_capture_chk #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push     (push),
  .fifo_full(fifo_full),
  .fifo_fill(fifo_fill),
  .ovf      (ovf),
  .ovr_clr  (ovr_clr),
  .rx_irq   (rx_irq),
  .rd_valid (rd_valid),
  .ovr_irq  (ovr_irq),
  .trans    (trans),
  .tick     (tick),
  .width_cnt(width_cnt),
  .dem_mark (dem_mark),
  .dem_edge (dem_edge),
  .demod_en (demod_en)
);

// File: tb/test_irpw_capture.sv
module test_irpw_capture;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        demod_en = 1'b0;
  logic [15:0] div_val = '0;
  logic        rd_en = 1'b0;
  logic [16:0] rd_data;
  logic        rd_valid;
  logic        rx_irq_en = 1'b0;
  logic        ovr_irq_en = 1'b0;
  logic        ovr_clr = 1'b0;
  logic        rx_irq;
  logic        ovr_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  irpw_capture i_irpw_capture (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .demod_en(demod_en),
    .div_val(div_val), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rx_irq_en(rx_irq_en), .ovr_irq_en(ovr_irq_en), .ovr_clr(ovr_clr),
    .rx_irq(rx_irq), .ovr_irq(ovr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic dm, input logic [15:0] dv);
    @(negedge clk);
    rst_n = 1'b0; ir_in = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    demod_en = dm; div_val = dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold(input logic v, input int n);
    ir_in = v;
    repeat (n) @(negedge clk);
  endtask

  // check the oldest entry, then remove it
  task automatic pop_expect(input logic lvl, input int exp_cnt, input int tol, input string tag);
    int c;
    chk(rd_valid == 1'b1, {tag, " valid"}, int'(rd_valid), 1);
    chk(rd_data[16] == lvl, {tag, " level"}, int'(rd_data[16]), int'(lvl));
    c = int'(rd_data[15:0]);
    chk((c >= exp_cnt - tol) && (c <= exp_cnt + tol), {tag, " count"}, c, exp_cnt);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 16'd0);
    rx_irq_en = 1'b1; ovr_irq_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_valid == 1'b0, "R11 empty", int'(rd_valid), 0);
    chk(rx_irq == 1'b0, "R11 rx_irq", int'(rx_irq), 0);
    chk(ovr_irq == 1'b0, "R11 ovr_irq", int'(ovr_irq), 0);
  endtask

  task automatic t_direct();
    do_reset(1'b0, 16'd0);
    hold(0, 5); hold(1, 6); hold(0, 9); hold(1, 4); hold(0, 10);
    pop_expect(1'b0, 0, 65535, "R2 initial space");
    pop_expect(1'b1, 6, 0, "R1 R2 mark 6");
    pop_expect(1'b0, 9, 0, "R2 R7 space 9");
    pop_expect(1'b1, 4, 0, "R1 R7 mark 4");
    chk(rd_valid == 1'b0, "R2 open pulse not pushed", int'(rd_valid), 0);
  endtask

  task automatic t_divider();
    do_reset(1'b0, 16'd3);
    hold(0, 8); hold(1, 20); hold(0, 12); hold(1, 8);
    pop_expect(1'b0, 0, 65535, "R3 initial space");
    pop_expect(1'b1, 5, 0, "R3 mark 20 cycles div 4");
    pop_expect(1'b0, 3, 0, "R3 space 12 cycles div 4");
  endtask

  task automatic t_saturate();
    do_reset(1'b0, 16'd0);
    hold(0, 4); hold(1, 70000); hold(0, 6);
    pop_expect(1'b0, 0, 65535, "R4 initial space");
    pop_expect(1'b1, 65535, 0, "R4 saturated mark");
  endtask

  task automatic t_demod();
    do_reset(1'b1, 16'd0);
    hold(0, 10);
    for (int i = 0; i < 6; i++) begin
      hold(1, 4); hold(0, 4);
    end
    hold(0, 60);
    pop_expect(1'b0, 0, 65535, "R5 space before burst");
    pop_expect(1'b1, 72, 2, "R6 demodulated mark");
    chk(rd_valid == 1'b0, "R6 trailing space open", int'(rd_valid), 0);
    hold(1, 60);
    chk(rd_valid == 1'b0, "R5 lone rising edge", int'(rd_valid), 0);
    hold(0, 40);
    chk(rd_valid == 1'b0, "R5 lone falling edge", int'(rd_valid), 0);
  endtask

  task automatic t_overrun();
    do_reset(1'b0, 16'd0);
    rx_irq_en = 1'b0; ovr_irq_en = 1'b1;
    hold(0, 3);
    for (int i = 0; i < 20; i++) hold(((i % 2) == 0), 3);
    repeat (4) @(negedge clk);
    chk(ovr_irq == 1'b1, "R8 R10 overrun raised", int'(ovr_irq), 1);
    ovr_irq_en = 1'b0;
    #1;
    chk(ovr_irq == 1'b0, "R10 overrun masked", int'(ovr_irq), 0);
    chk(rx_irq == 1'b0, "R9 rx masked", int'(rx_irq), 0);
    rx_irq_en = 1'b1;
    #1;
    chk(rx_irq == 1'b1, "R9 rx raised", int'(rx_irq), 1);
    @(negedge clk);
    pop_expect(1'b0, 0, 65535, "R7 first entry");
    for (int k = 2; k <= 16; k++)
      pop_expect(((k % 2) == 0), 3, 0, "R7 R8 kept entry");
    chk(rd_valid == 1'b0, "R8 extra pushes discarded", int'(rd_valid), 0);
    chk(rx_irq == 1'b0, "R9 rx drops when empty", int'(rx_irq), 0);
    ovr_irq_en = 1'b1;
    #1;
    chk(ovr_irq == 1'b1, "R8 flag sticky", int'(ovr_irq), 1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr_irq == 1'b0, "R8 flag cleared", int'(ovr_irq), 0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_divider();
    t_saturate();
    t_demod();
    t_overrun();
    summary();
    $finish;
  end
endmodule